// File: doc/BRIEF.md
# Serial memory status register and write guard

This block keeps the status byte of a serial nonvolatile memory and decides which writes may proceed. It holds a hardware-lock enable bit, a two-bit block-protect code, the write-enable latch and a view of the external busy flag. It also answers two questions every cycle: may the byte at the query address be programmed, and may the status register be written? The serial front end feeds it decoded commands. A separate timing unit drives the busy flag while a program cycle runs.

A status write is taken in while the device is selected and is held pending. It takes effect on the rising edge of the active-low select. A falling lock pin during the selection can drop the pending write, but only when the lock enable is set. The protect code always guards a region counted down from the highest address. All pins are plain level or single-cycle pulse controls. There is no streaming interface and no back-pressure.

Top module: `nvm_status_guard`

## Requirements
- R1: When busy_i is low, status_byte is {lock enable, 3'b000, block code[1:0], write-enable latch, 1'b0}. Bit 7 is the lock enable, bits 3:2 are the block code and bit 1 is the latch.
- R2: While busy_i is high, status_byte reads 8'hFF, and both array_wr_ok and status_wr_ok are 0.
- R3: For the 8192-byte default array, block code 00 guards nothing. Code 01 guards 0x1800..0x1FFF, code 10 guards 0x1000..0x1FFF, and code 11 guards every address.
- R4: array_wr_ok is 1 only when the latch is set, busy_i is low and q_addr is outside the guarded region. A guarded address is never writable.
- R5: The hardware lock is active when lock_pin_n is 0 and the lock enable is 1. While it is active, status_wr_ok is 0 and status writes are refused, including a write that would clear the enable. Otherwise status_wr_ok follows the latch while busy_i is low.
- R6: A we_arm pulse sets the latch and a we_disarm pulse clears it. Clear wins when both arrive in the same cycle. Clearing works whatever the level of lock_pin_n. Both pulses are ignored while busy_i is high. The latch is clear after reset.
- R7: The cycle after busy_i falls, the latch is clear.
- R8: A st_wr_stb pulse while sel_n is 0 and status_wr_ok is 1 captures st_wr_data. If several pulses arrive, the last one is kept. The captured value is stored on the rising edge of sel_n. Only data bits 7, 3 and 2 are stored, and bits 6:4 and 1:0 have no effect. A strobe while sel_n is 1 is ignored.
- R9: If lock_pin_n falls while sel_n is 0 and the lock enable is 1, the pending status write is dropped. When the lock enable is 0, a fall of the pin has no effect on it.
- R10: After reset, the lock enable and the block code take the values of parameters RST_LOCK_EN and RST_BLK (both 0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low device select; a rising edge stores a pending status write |
| lock_pin_n | input | 1 | Hardware lock pin; low requests the lock |
| we_arm | input | 1 | Pulse: set the write-enable latch |
| we_disarm | input | 1 | Pulse: clear the write-enable latch |
| st_wr_stb | input | 1 | Pulse: status write data valid |
| st_wr_data | input | 8 | Status write data |
| busy_i | input | 1 | Internal program cycle in progress |
| q_addr | input | ADDR_W | Array address being queried |
| status_byte | output | 8 | Status value for reads |
| array_wr_ok | output | 1 | Byte at q_addr may be programmed |
| status_wr_ok | output | 1 | Status register may be written |

## Verification
The assertions assume that we_arm, we_disarm and st_wr_stb are one-cycle pulses. They also assume that all inputs are synchronous to clk, so that edges of sel_n and lock_pin_n are seen one cycle apart as registered transitions. The bench changes every input one time unit after a rising clock edge and holds each pulse for exactly one cycle. It raises busy_i only between complete select windows, as the program-cycle timer would.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

  // Nonvolatile protect state.
  typedef struct packed {
    logic       lock_en;
    logic [1:0] blk;
  } nv_bits_t;

  // Is a region guarded, given the block code and the two top address bits?
  function automatic logic blk_hit(input logic [1:0] code, input logic [1:0] top2);
    case (code)
      2'b00:   blk_hit = 1'b0;
      2'b01:   blk_hit = (top2 == 2'b11);
      2'b10:   blk_hit = top2[1];
      default: blk_hit = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/nsg_prot_decode.sv
module nsg_prot_decode #(
  parameter int ADDR_W = 13
) (
  input  logic [1:0]        blk,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  import nsg_pkg::*;

  logic [1:0] top2;

  generate
    if (ADDR_W > 2) begin : g_wide
      logic unused_low;
      assign top2       = addr[ADDR_W-1 -: 2];
      assign unused_low = ^addr[ADDR_W-3:0];
    end else begin : g_narrow
      assign top2 = addr[1:0];
    end
  endgenerate

  assign prot = blk_hit(blk, top2);

endmodule

// File: rtl/nsg_wel.sv
module nsg_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic disarm,
  input  logic busy_i,
  output logic latch
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (busy_q && !busy_i) latch <= 1'b0;
      else if (!busy_i) begin
        if (disarm)   latch <= 1'b0;
        else if (arm) latch <= 1'b1;
      end
    end
  end

  AST_LATCH_DROPS_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !busy_i) |=> !latch); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm && !busy_i) |=> !latch); // R6

endmodule

// File: rtl/nsg_stwr.sv
module nsg_stwr
  import nsg_pkg::*;
#(
  parameter logic       RST_LOCK_EN = 1'b0,
  parameter logic [1:0] RST_BLK     = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       lock_pin_n,
  input  logic       stb,
  input  logic [7:0] data,
  input  logic       permit,
  output nv_bits_t   nv
);
  logic     sel_q, lock_q, pend;
  nv_bits_t pend_data;
  logic     sel_rise, lock_fall, commit;
  logic     unused_bits;

  assign unused_bits = ^{data[6:4], data[1:0]};
  assign sel_rise    = sel_n && !sel_q;
  assign lock_fall   = lock_q && !lock_pin_n;
  assign commit      = sel_rise && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b1;
      lock_q    <= 1'b1;
      pend      <= 1'b0;
      pend_data <= '0;
      nv        <= '{lock_en: RST_LOCK_EN, blk: RST_BLK};
    end else begin
      sel_q  <= sel_n;
      lock_q <= lock_pin_n;
      if (sel_n) pend <= 1'b0;
      else if (lock_fall && nv.lock_en) pend <= 1'b0;
      else if (stb && permit) begin
        pend      <= 1'b1;
        pend_data <= '{lock_en: data[7], blk: data[3:2]};
      end
      if (commit) nv <= pend_data;
    end
  end

  AST_CANCEL_ON_PIN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && lock_fall && nv.lock_en) |=> !pend); // R9

  AST_NV_HOLDS_OUTSIDE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_rise |=> $stable(nv)); // R8

endmodule

// File: rtl/nvm_status_guard.sv
module nvm_status_guard
  import nsg_pkg::*;
#(
  parameter int         ADDR_W      = 13,
  parameter logic       RST_LOCK_EN = 1'b0,
  parameter logic [1:0] RST_BLK     = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              lock_pin_n,
  input  logic              we_arm,
  input  logic              we_disarm,
  input  logic              st_wr_stb,
  input  logic [7:0]        st_wr_data,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] q_addr,
  output logic [7:0]        status_byte,
  output logic              array_wr_ok,
  output logic              status_wr_ok
);
  nv_bits_t nv;
  logic     latch, prot, hw_lock;

  nsg_wel u_wel (
    .clk(clk), .rst_n(rst_n), .arm(we_arm), .disarm(we_disarm),
    .busy_i(busy_i), .latch(latch)
  );

  nsg_stwr #(.RST_LOCK_EN(RST_LOCK_EN), .RST_BLK(RST_BLK)) u_stwr (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .lock_pin_n(lock_pin_n),
    .stb(st_wr_stb), .data(st_wr_data), .permit(status_wr_ok), .nv(nv)
  );

  nsg_prot_decode #(.ADDR_W(ADDR_W)) u_dec (
    .blk(nv.blk), .addr(q_addr), .prot(prot)
  );

  assign hw_lock      = nv.lock_en && !lock_pin_n;
  assign status_wr_ok = latch && !busy_i && !hw_lock;
  assign array_wr_ok  = latch && !busy_i && !prot;
  assign status_byte  = busy_i ? 8'hFF : {nv.lock_en, 3'b000, nv.blk, latch, 1'b0};

  AST_BUSY_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (!array_wr_ok && !status_wr_ok)); // R2

  AST_LOCK_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[7] && !busy_i && !lock_pin_n) |-> !status_wr_ok); // R5

  AST_TOP_ADDR_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_byte[3:2] != 2'b00) && (&q_addr)) |-> !array_wr_ok); // R3

  AST_NO_WRITE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !status_byte[1]) |-> (!array_wr_ok && !status_wr_ok)); // R4

endmodule

// File: tb/nvm_status_guard_tb.sv
module nvm_status_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, lock_pin_n = 1'b1, we_arm = 1'b0, we_disarm = 1'b0;
  logic st_wr_stb = 1'b0, busy_i = 1'b0;
  logic [7:0] st_wr_data = '0;
  logic [ADDR_W-1:0] q_addr = '0;
  logic [7:0] status_byte;
  logic array_wr_ok, status_wr_ok;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_status_guard #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .lock_pin_n(lock_pin_n),
    .we_arm(we_arm), .we_disarm(we_disarm), .st_wr_stb(st_wr_stb),
    .st_wr_data(st_wr_data), .busy_i(busy_i), .q_addr(q_addr),
    .status_byte(status_byte), .array_wr_ok(array_wr_ok), .status_wr_ok(status_wr_ok)
  );

  // {block code[1:0], address[12:0], expected array_wr_ok}
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {2'b00, 13'h0000, 1'b1}, {2'b00, 13'h1FFF, 1'b1},
    {2'b01, 13'h17FF, 1'b1}, {2'b01, 13'h1800, 1'b0}, {2'b01, 13'h1FFF, 1'b0},
    {2'b10, 13'h0FFF, 1'b1}, {2'b10, 13'h1000, 1'b0},
    {2'b11, 13'h0000, 1'b0}, {2'b11, 13'h0FFF, 1'b0}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic arm();    we_arm = 1'b1;    step(); we_arm = 1'b0;    endtask
  task automatic disarm(); we_disarm = 1'b1; step(); we_disarm = 1'b0; endtask
  task automatic strobe(input logic [7:0] d);
    st_wr_data = d; st_wr_stb = 1'b1; step(); st_wr_stb = 1'b0;
  endtask
  task automatic busy_pulse();
    busy_i = 1'b1; step(); step(); busy_i = 1'b0; step();
  endtask
  task automatic set_status(input logic [7:0] d);
    arm(); sel_n = 1'b0; step(); strobe(d); sel_n = 1'b1; step();
    busy_pulse(); arm();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step();
    chk("R10 reset status", status_byte, 8'h00);
    chk("R6 reset latch clear array_wr_ok", {7'd0, array_wr_ok}, 8'd0);
    chk("R6 reset latch clear status_wr_ok", {7'd0, status_wr_ok}, 8'd0);
    rst_n = 1'b1; step();

    for (int i = 0; i < NV; i++) begin
      set_status({4'b0000, VEC[i][15:14], 2'b00});
      q_addr = VEC[i][13:1];
      #1;
      chk($sformatf("R3 R4 code=%b addr=%h", VEC[i][15:14], VEC[i][13:1]),
          {7'd0, array_wr_ok}, {7'd0, VEC[i][0]});
    end
    // now: lock_en=0, blk=11, latch=1
    chk("R1 layout", status_byte, 8'h0E);

    disarm();
    chk("R6 disarm", status_byte, 8'h0C);
    we_arm = 1'b1; we_disarm = 1'b1; step(); we_arm = 1'b0; we_disarm = 1'b0;
    chk("R6 clear wins", status_byte, 8'h0C);

    busy_i = 1'b1; step(); arm();
    chk("R2 busy reads ones", status_byte, 8'hFF);
    chk("R2 busy permits", {6'd0, array_wr_ok, status_wr_ok}, 8'd0);
    busy_i = 1'b0; step();
    chk("R6 arm ignored while busy", status_byte, 8'h0C);

    arm();
    chk("R6 arm sets latch", status_byte, 8'h0E);
    busy_pulse();
    chk("R7 latch drops after cycle", status_byte, 8'h0C);

    arm(); sel_n = 1'b0; step(); strobe(8'hF3); sel_n = 1'b1; step();
    chk("R8 ignored data bits", status_byte, 8'h82);
    busy_pulse();
    chk("R1 R7 enable stored", status_byte, 8'h80);

    lock_pin_n = 1'b0; step(); arm();
    chk("R5 locked status_wr_ok", {7'd0, status_wr_ok}, 8'd0);
    q_addr = 13'h1FFF; #1;
    chk("R4 array writable when locked", {7'd0, array_wr_ok}, 8'd1);
    sel_n = 1'b0; step(); strobe(8'h00); sel_n = 1'b1; step();
    chk("R5 refused clear of enable", status_byte, 8'h82);

    lock_pin_n = 1'b1; step();
    chk("R5 pin high permits", {7'd0, status_wr_ok}, 8'd1);
    sel_n = 1'b0; step(); strobe(8'h04);
    lock_pin_n = 1'b0; step(); lock_pin_n = 1'b1; step();
    sel_n = 1'b1; step();
    chk("R9 pin fall cancels", status_byte, 8'h82);

    sel_n = 1'b0; step(); strobe(8'h00); sel_n = 1'b1; step();
    chk("R8 commit on select rise", status_byte, 8'h02);

    lock_pin_n = 1'b0; step();
    chk("R5 enable 0 permits", {7'd0, status_wr_ok}, 8'd1);
    disarm();
    chk("R6 clear with pin low", status_byte, 8'h00);

    lock_pin_n = 1'b1; step(); arm();
    sel_n = 1'b0; step(); strobe(8'h08);
    lock_pin_n = 1'b0; step(); sel_n = 1'b1; step();
    chk("R9 no cancel when enable 0", status_byte, 8'h0A);

    strobe(8'h00); step();
    chk("R8 strobe while deselected", status_byte, 8'h0A);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule